// File: doc/BRIEF.md
# Wake Event Status and Routing

This block keeps a small set of sticky event flags in one 32-bit register and turns them into system-level requests. Each flag is set by hardware on the rising edge of an event input, after a synchroniser, and stays set until software writes a one to its position. The event inputs are a power-management event line (active low), a ring-indicate line (active low), a watchdog interrupt request, and a management-bus wake request that carries its cause.

Each enabled flag is combined with the current sleep state. While the system is awake, a flag raises an interrupt. While the system sleeps normally, it raises a wake request together with an interrupt. After a forced shutdown by power-button override, it raises nothing. A mode bit selects whether the interrupt goes out as a system control interrupt or as a management interrupt.

The management-bus wake flag behaves differently. It is never a source of interrupts and only requests wakes. A thermal-trip or power-button-override event erases it when a bus command set it, but not when the alert pin set it.

Top module: `wake_evt_router`

## Requirements
- R1: Out of reset, `reg_rdata` is 0. The bit positions are: 11 = power event, 8 = ring indicate, 7 = management-bus wake, 6 = watchdog. Every other bit reads 0.
- R2: Writing with `reg_wr` clears each flag whose `reg_wdata` bit is 1. A 0 in a bit position leaves that flag unchanged.
- R3: The power-event flag sets once per high-to-low transition of `pme_n`, and the ring-indicate flag sets once per high-to-low transition of `ri_n`. Holding either line low does not set the flag again after it has been cleared.
- R4: The watchdog flag sets on each rising edge of `tco_sci_req`.
- R5: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: With `sleep_state` = 0 (awake), the power-event flag with `pme_en` high drives `sci_req` if `sci_mode` is 1, otherwise it drives `smi_req`. `wake_req` stays 0, and `sci_req` and `smi_req` are never high together.
- R7: With `sleep_state` 1 to 4, or 5 with `s5_forced` low, the enabled power-event flag drives `wake_req` together with the interrupt chosen by `sci_mode`.
- R8: With `sleep_state` 5 and `s5_forced` high, or with `sleep_state` 6 or 7, `wake_req`, `sci_req` and `smi_req` are all 0.
- R9: The ring-indicate flag is routed in the same way as the power-event flag, gated by `ri_en`.
- R10: The management-bus wake flag sets on a rising edge of `smb_wake_req` in any sleep state, including awake. It never drives `sci_req` or `smi_req`. It drives `wake_req` in the sleeping states of R7 without needing an enable.
- R11: A rising edge of `therm_trip` or `pwrbtn_ovr` clears the management-bus wake flag if it was last set with `smb_alert_cause` = 0 (bus command). The flag is kept if any set since the last clear had `smb_alert_cause` = 1 (alert pin).
- R12: A flag whose enable is 0 drives no output, and the flag stays readable as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pme_n | input | 1 | Power-management event, active low, asynchronous |
| ri_n | input | 1 | Ring indicate, active low, asynchronous |
| tco_sci_req | input | 1 | Watchdog logic interrupt request |
| smb_wake_req | input | 1 | Management-bus wake request |
| smb_alert_cause | input | 1 | Cause of the bus wake: 1 = alert pin, 0 = slave command |
| therm_trip | input | 1 | Thermal-trip event |
| pwrbtn_ovr | input | 1 | Power-button-override event |
| sleep_state | input | 3 | 0 = awake, 1 to 5 = sleep depth, 6 and 7 reserved |
| s5_forced | input | 1 | Deepest state was entered by button override |
| pme_en | input | 1 | Enable for the power-event flag |
| ri_en | input | 1 | Enable for the ring-indicate flag |
| sci_mode | input | 1 | 1 = system control interrupt, 0 = management interrupt |
| reg_wr | input | 1 | Register write strobe (write-one-to-clear) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| wake_req | output | 1 | Wake request level |
| sci_req | output | 1 | System control interrupt level |
| smi_req | output | 1 | Management interrupt level |

## Verification
The hardest case to reach from the ports is a hardware set that lands in the same cycle as a software clear. The set arrives only after the synchroniser and edge-detect stages. The stimulus therefore drops the event line and raises the clear strobe exactly two edges later.

The conditional clearing of the bus wake flag is also hard to reach, because it depends on the cause history of the flag. Random sequences mix command and alert wakes with thermal and override events. Directed cases cover a command wake that is then erased, and an alert wake that survives.

// File: rtl/wake_evt_pkg.sv
// Shared constants and types for the wake event router.
// Assumes a single 32-bit status register; bit positions are fixed
// because the event software decodes them.
package wake_evt_pkg;
    localparam int REG_W   = 32;
    localparam int BIT_PME = 11;
    localparam int BIT_RI  = 8;
    localparam int BIT_SMB = 7;
    localparam int BIT_TCO = 6;

    // indices into the synchroniser vector
    localparam int EV_PME   = 0;
    localparam int EV_RI    = 1;
    localparam int EV_TCO   = 2;
    localparam int EV_SMB   = 3;
    localparam int EV_THERM = 4;
    localparam int EV_PBO   = 5;
    localparam int EV_ALERT = 6;
    localparam int NUM_SYNC = 7;

    localparam logic [2:0] ST_AWAKE = 3'd0;
    localparam logic [2:0] ST_DEEP  = 3'd5;

    typedef struct packed {
        logic pme;
        logic ri;
        logic smb;
        logic tco;
        logic smb_by_alert;
    } evt_sts_t;
endpackage

// File: rtl/wer_edge_sync.sv
// Synchronises a vector of asynchronous active-high inputs and
// produces a one-cycle pulse on each rising edge. Assumes STAGES >= 2
// and that inputs stay stable for more than one clock.
module wer_edge_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        // shift the input through the synchroniser and remember last level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= (chain << 1) | STAGES'(async_i[g]);
                prev  <= chain[STAGES-1];
            end
        end

        assign lvl_o[g]  = chain[STAGES-1];
        assign rise_o[g] = chain[STAGES-1] & ~prev;

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]); // R3
    end
endmodule

// File: rtl/wer_status.sv
// Sticky write-one-to-clear event flags. A hardware set beats a
// software clear in the same cycle. The bus wake flag also records
// whether an alert contributed, which protects it from event clears.
module wer_status
    import wake_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_pme,
    input  logic             set_ri,
    input  logic             set_tco,
    input  logic             set_smb,
    input  logic             smb_alert,
    input  logic             clr_smb_evt,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output evt_sts_t         sts_o
);
    evt_sts_t nxt;
    logic     w_pme, w_ri, w_smb, w_tco;

    // decode which flags the current write clears
    always_comb begin
        w_pme = wr_en & wr_data[BIT_PME];
        w_ri  = wr_en & wr_data[BIT_RI];
        w_smb = wr_en & wr_data[BIT_SMB];
        w_tco = wr_en & wr_data[BIT_TCO];
    end

    // next-state of each flag: set wins over clear
    always_comb begin
        nxt.pme = set_pme | (sts_o.pme & ~w_pme);
        nxt.ri  = set_ri  | (sts_o.ri  & ~w_ri);
        nxt.tco = set_tco | (sts_o.tco & ~w_tco);
        if (set_smb) begin
            nxt.smb          = 1'b1;
            nxt.smb_by_alert = (sts_o.smb & sts_o.smb_by_alert) | smb_alert;
        end else begin
            nxt.smb = sts_o.smb & ~w_smb
                    & ~(clr_smb_evt & ~sts_o.smb_by_alert);
            nxt.smb_by_alert = nxt.smb & sts_o.smb_by_alert;
        end
    end

    // flag register
    always_ff @(posedge clk) begin
        if (!rst_n) sts_o <= '0;
        else        sts_o <= nxt;
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        set_pme |=> sts_o.pme); // R5
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o.tco && !w_tco) |=> sts_o.tco); // R2
    AST_ALERT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o.smb && sts_o.smb_by_alert && !w_smb) |=> sts_o.smb); // R11
    AST_CMD_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o.smb && !sts_o.smb_by_alert && clr_smb_evt && !set_smb)
        |=> !sts_o.smb); // R11
endmodule

// File: rtl/wer_route.sv
// Combines flags, enables and sleep state into wake and interrupt
// levels. Assumes sleep codes 0..5 with 6 and 7 reserved (silent).
module wer_route
    import wake_evt_pkg::*;
(
    input  evt_sts_t   sts,
    input  logic       pme_en,
    input  logic       ri_en,
    input  logic       sci_mode,
    input  logic [2:0] sleep_state,
    input  logic       s5_forced,
    output logic       wake_o,
    output logic       sci_o,
    output logic       smi_o
);
    logic awake, asleep, gen_evt, int_fire;

    // classify the sleep state
    always_comb begin
        awake  = (sleep_state == ST_AWAKE);
        asleep = ((sleep_state != ST_AWAKE) && (sleep_state < ST_DEEP))
               || ((sleep_state == ST_DEEP) && !s5_forced);
    end

    // route enabled flags to the outputs
    always_comb begin
        gen_evt  = (sts.pme & pme_en) | (sts.ri & ri_en);
        int_fire = gen_evt & (awake | asleep);
        wake_o   = asleep & (gen_evt | sts.smb);
        sci_o    = int_fire & sci_mode;
        smi_o    = int_fire & ~sci_mode;
    end
endmodule

// File: rtl/wake_evt_router.sv
// Top of the wake event router: synchronises the event inputs,
// keeps the sticky flags and routes them by sleep state.
// Assumes asynchronous event inputs and a single-register W1C port.
module wake_evt_router
    import wake_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pme_n,
    input  logic             ri_n,
    input  logic             tco_sci_req,
    input  logic             smb_wake_req,
    input  logic             smb_alert_cause,
    input  logic             therm_trip,
    input  logic             pwrbtn_ovr,
    input  logic [2:0]       sleep_state,
    input  logic             s5_forced,
    input  logic             pme_en,
    input  logic             ri_en,
    input  logic             sci_mode,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             wake_req,
    output logic             sci_req,
    output logic             smi_req
);
    logic [NUM_SYNC-1:0] raw, lvl, rise;
    evt_sts_t            sts;

    // present every event as active-high before synchronising
    always_comb begin
        raw           = '0;
        raw[EV_PME]   = ~pme_n;
        raw[EV_RI]    = ~ri_n;
        raw[EV_TCO]   = tco_sci_req;
        raw[EV_SMB]   = smb_wake_req;
        raw[EV_THERM] = therm_trip;
        raw[EV_PBO]   = pwrbtn_ovr;
        raw[EV_ALERT] = smb_alert_cause;
    end

    wer_edge_sync #(.WIDTH(NUM_SYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .lvl_o   (lvl),
        .rise_o  (rise)
    );

    wer_status status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_pme     (rise[EV_PME]),
        .set_ri      (rise[EV_RI]),
        .set_tco     (rise[EV_TCO]),
        .set_smb     (rise[EV_SMB]),
        .smb_alert   (lvl[EV_ALERT]),
        .clr_smb_evt (rise[EV_THERM] | rise[EV_PBO]),
        .wr_en       (reg_wr),
        .wr_data     (reg_wdata),
        .sts_o       (sts)
    );

    wer_route route_i (
        .sts         (sts),
        .pme_en      (pme_en),
        .ri_en       (ri_en),
        .sci_mode    (sci_mode),
        .sleep_state (sleep_state),
        .s5_forced   (s5_forced),
        .wake_o      (wake_req),
        .sci_o       (sci_req),
        .smi_o       (smi_req)
    );

    // assemble the read word; unused positions read zero
    always_comb begin
        reg_rdata          = '0;
        reg_rdata[BIT_PME] = sts.pme;
        reg_rdata[BIT_RI]  = sts.ri;
        reg_rdata[BIT_SMB] = sts.smb;
        reg_rdata[BIT_TCO] = sts.tco;
    end

    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sci_req && smi_req)); // R6
    AST_AWAKE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == ST_AWAKE) |-> !wake_req); // R6
    AST_FORCED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (((sleep_state == ST_DEEP) && s5_forced) || (sleep_state > ST_DEEP))
        |-> !(wake_req || sci_req || smi_req)); // R8
    AST_NO_INT_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pme_en && !ri_en) |-> !(sci_req || smi_req)); // R12
endmodule

// File: tb/wake_evt_router_tb_top.sv
module wake_evt_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pme_n = 1'b1, ri_n = 1'b1, tco_sci_req = 1'b0;
    logic        smb_wake_req = 1'b0, smb_alert_cause = 1'b0;
    logic        therm_trip = 1'b0, pwrbtn_ovr = 1'b0;
    logic [2:0]  sleep_state = 3'd0;
    logic        s5_forced = 1'b0, pme_en = 1'b0, ri_en = 1'b0, sci_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wake_req, sci_req, smi_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the flags
    bit m_pme, m_ri, m_smb, m_tco, m_alert;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_evt_router dut_i (
        .clk(clk), .rst_n(rst_n), .pme_n(pme_n), .ri_n(ri_n),
        .tco_sci_req(tco_sci_req), .smb_wake_req(smb_wake_req),
        .smb_alert_cause(smb_alert_cause), .therm_trip(therm_trip),
        .pwrbtn_ovr(pwrbtn_ovr), .sleep_state(sleep_state),
        .s5_forced(s5_forced), .pme_en(pme_en), .ri_en(ri_en),
        .sci_mode(sci_mode), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wake_req(wake_req), .sci_req(sci_req),
        .smi_req(smi_req)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[11] = m_pme; w[8] = m_ri; w[7] = m_smb; w[6] = m_tco;
        return w;
    endfunction

    // expected {wake, sci, smi} from the routing requirements
    function automatic logic [2:0] exp_route();
        bit awake = (sleep_state == 3'd0);
        bit sleeping = (sleep_state >= 3'd1 && sleep_state <= 3'd4) ||
                       (sleep_state == 3'd5 && !s5_forced);
        bit src = (m_pme && pme_en) || (m_ri && ri_en);
        bit intr = src && (awake || sleeping);
        return {sleeping && (src || m_smb), intr && sci_mode, intr && !sci_mode};
    endfunction

    function automatic string route_tag();
        if (sleep_state == 3'd0) return "R6";
        if (sleep_state > 3'd5 || (sleep_state == 3'd5 && s5_forced)) return "R8";
        return "R7";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, reg_rdata, exp_word());
        chk(route_tag(), {29'd0, wake_req, sci_req, smi_req}, {29'd0, exp_route()});
    endtask

    // pulse one event input: 0 pme,1 ri,2 tco,3 smb,4 therm,5 override
    task automatic fire(int which, bit alert);
        @(negedge clk);
        case (which)
            0: pme_n = 1'b0;
            1: ri_n = 1'b0;
            2: tco_sci_req = 1'b1;
            3: begin smb_alert_cause = alert; smb_wake_req = 1'b1; end
            4: therm_trip = 1'b1;
            default: pwrbtn_ovr = 1'b1;
        endcase
        repeat (3) @(negedge clk);
        pme_n = 1'b1; ri_n = 1'b1; tco_sci_req = 1'b0; smb_wake_req = 1'b0;
        therm_trip = 1'b0; pwrbtn_ovr = 1'b0;
        repeat (4) @(negedge clk);
        smb_alert_cause = 1'b0;
        case (which)
            0: m_pme = 1;
            1: m_ri = 1;
            2: m_tco = 1;
            3: begin m_alert = (m_smb && m_alert) || alert; m_smb = 1; end
            default: if (m_smb && !m_alert) begin m_smb = 0; m_alert = 0; end
        endcase
    endtask

    task automatic clr(logic [31:0] mask);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = mask;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        if (mask[11]) m_pme = 0;
        if (mask[8]) m_ri = 0;
        if (mask[6]) m_tco = 0;
        if (mask[7]) begin m_smb = 0; m_alert = 0; end
    endtask

    task automatic cfg(logic [2:0] st, bit forced, bit pe, bit re, bit mode);
        @(negedge clk);
        sleep_state = st; s5_forced = forced; pme_en = pe; ri_en = re; sci_mode = mode;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", reg_rdata, 32'd0);
        chk("R1 reset outputs", {29'd0, wake_req, sci_req, smi_req}, 32'd0);

        // R1 layout, R3 set on falling pme_n, R6 awake routing
        fire(0, 0);
        chk("R1 pme at bit 11", reg_rdata, 32'h0000_0800);
        cfg(3'd0, 0, 1, 0, 1);
        check_all("R6 sci mode");
        cfg(3'd0, 0, 1, 0, 0);
        check_all("R6 smi mode");
        // R7 sleeping routing
        cfg(3'd3, 0, 1, 0, 1);
        check_all("R7 sleep S3");
        cfg(3'd5, 0, 1, 0, 0);
        check_all("R7 soft S5");
        // R8 forced and reserved
        cfg(3'd5, 1, 1, 0, 1);
        check_all("R8 forced S5");
        cfg(3'd7, 0, 1, 0, 1);
        check_all("R8 reserved code");
        // R12 disabled source: no output, flag still visible
        cfg(3'd2, 0, 0, 0, 1);
        chk("R12 disabled outputs", {29'd0, wake_req, sci_req, smi_req}, 32'd0);
        chk("R12 flag kept", reg_rdata, 32'h0000_0800);
        // R2 zero write has no effect, one clears
        clr(32'hFFFF_F7FF);
        check_all("R2 zero bit keeps");
        clr(32'h0000_0800);
        check_all("R2 one clears");
        // R9 ring indicate
        fire(1, 0);
        cfg(3'd1, 0, 0, 1, 0);
        check_all("R9 ri sleeping");
        chk("R9 ri wake", {31'd0, wake_req}, 32'd1);
        clr(32'h0000_0100);
        // R4 watchdog
        fire(2, 0);
        chk("R4 tco bit 6", reg_rdata, 32'h0000_0040);
        clr(32'h0000_0040);
        // R10 bus wake while awake, no interrupt
        cfg(3'd0, 0, 1, 1, 1);
        fire(3, 0);
        check_all("R10 smb awake");
        chk("R10 no interrupt", {30'd0, sci_req, smi_req}, 32'd0);
        cfg(3'd4, 0, 0, 0, 1);
        chk("R10 smb wakes", {31'd0, wake_req}, 32'd1);
        // R11 command wake erased by thermal trip
        fire(4, 0);
        chk("R11 command erased", reg_rdata, 32'd0);
        // R11 alert wake survives override
        fire(3, 1);
        fire(5, 0);
        chk("R11 alert kept", reg_rdata, 32'h0000_0080);
        clr(32'h0000_0080);
        // R3 held level does not re-set after clear
        @(negedge clk); pme_n = 1'b0;
        repeat (5) @(negedge clk);
        clr(32'h0000_0800);
        repeat (5) @(negedge clk);
        chk("R3 held low once", reg_rdata, 32'd0);
        pme_n = 1'b1;
        repeat (5) @(negedge clk);
        // R5 set lands with clear in the same cycle
        fire(0, 0);
        @(negedge clk); pme_n = 1'b0;
        @(negedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h0000_0800;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
        chk("R5 set beats clear", reg_rdata, 32'h0000_0800);
        pme_n = 1'b1;
        repeat (5) @(negedge clk);
        m_pme = 1;

        // random mix
        for (int i = 0; i < 400; i++) begin
            int act = $urandom % 8;
            if (act < 6) begin
                fire(act, $urandom % 2);
                case (act)
                    0, 1: check_all("R3 random");
                    2: check_all("R4 random");
                    3: check_all("R10 random");
                    default: check_all("R11 random");
                endcase
            end else if (act == 6) begin
                clr($urandom & $urandom);
                check_all("R2 random");
            end else begin
                cfg(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
                check_all("R12 random");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule